// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a single-wire bus slave. A bit engine below it turns bus waveforms into three events: a bus reset, a completed time slot with the bit seen on the line, and the bit the slave must put on the line in the next read slot. After every bus reset the layer collects an 8-bit ROM command. It then reads out the 64-bit identifier, compares it against an address from the master, takes part in a binary-tree search, or selects the device at once. When the device ends up addressed, it raises `selected` and leaves the bus to the function-command layer until the next reset.

The layer keeps the resume flag, which lets a master that has already addressed this device get back to it with one short command. It also keeps the overdrive flag that tells the bit engine to switch to fast timing. The identifier comes in on a port: an 8-bit family code in bits 7:0, the 48-bit serial number in bits 55:8 and the CRC byte in bits 63:56. The layer acts only on events from the bit engine and never starts a slot itself.

Top module: `romCommandLayer`

## Requirements
- R1: After `rstN` low, `selected`, `txEn`, `overdrive` and `resumeFlag` are 0, and slots are ignored until the first bus reset.
- R2: After a bus reset, the command is taken from 8 slots, least significant bit first. No command acts before its 8th bit. Codes: 8'h33 read, 8'h55 match, 8'hF0 search, 8'hCC skip, 8'hA5 resume, 8'h3C overdrive-skip, 8'h69 overdrive-match.
- R3: Read drives all 64 identifier bits, bit 0 first (`txEn`=1, `txBit`=identifier bit), one per slot. After the 64th slot `selected` is 1.
- R4: Match compares 64 received bits, bit 0 first. A full match sets `selected` and `resumeFlag`. On any mismatch the device stays unselected, with `txEn`=0, until the next bus reset.
- R5: Search uses three slots per identifier bit, bit 0 first. In the first slot the device sends the bit, in the second its complement, and in the third it reads the master's choice. A differing choice drops the device out until reset. Completing all 64 bits sets `selected` and `resumeFlag`.
- R6: Skip, overdrive-skip, and the start of match, search or overdrive-match clear `resumeFlag`. Read and unknown codes leave it unchanged. `resumeFlag` is set only when a match or search succeeds.
- R7: Resume selects the device when `resumeFlag` is 1. Otherwise the device idles until reset.
- R8: Overdrive-skip sets `overdrive` and `selected` as soon as the command completes.
- R9: Overdrive-match sets `overdrive` when the command completes. On an address mismatch, `overdrive` returns to its value before the command.
- R10: A bus reset with `busResetLong`=1 clears `overdrive`. A short bus reset leaves it unchanged.
- R11: An unknown command code leaves the device unselected and silent until the next bus reset.
- R12: A bus reset at any point aborts the current command and returns to command reception. It wins over a slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idValue | input | ID_W | Identifier: family code, serial, CRC byte |
| busReset | input | 1 | One-cycle strobe: bus reset seen |
| busResetLong | input | 1 | With busReset: reset pulse was of standard-speed length |
| slotValid | input | 1 | One-cycle strobe: a time slot completed |
| rxBit | input | 1 | Line level sampled in that slot |
| txEn | output | 1 | Device sends a bit in the next slot |
| txBit | output | 1 | Bit to send (0 means pull the line low) |
| overdrive | output | 1 | Request for fast bit timing |
| resumeFlag | output | 1 | Resume flag |
| selected | output | 1 | Control passed to the function layer |

## Verification
Every output is registered, so each result shows one clock after the `slotValid` or `busReset` strobe that causes it. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, after that single register stage. Read and search bits are captured at the falling edge before the slot strobe that consumes them. The flag and selection checks are made one falling edge after the final slot of a command.

// File: rtl/romLayerPkg.sv
`timescale 1ns/1ps
package romLayerPkg;
  localparam logic [7:0] OP_READ      = 8'h33;
  localparam logic [7:0] OP_MATCH     = 8'h55;
  localparam logic [7:0] OP_SEARCH    = 8'hF0;
  localparam logic [7:0] OP_SKIP      = 8'hCC;
  localparam logic [7:0] OP_RESUME    = 8'hA5;
  localparam logic [7:0] OP_FAST_SKIP = 8'h3C;
  localparam logic [7:0] OP_FAST_MTCH = 8'h69;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_READ, ST_MATCH,
    ST_SRCH_TRUE, ST_SRCH_COMP, ST_SRCH_PICK, ST_FUNC
  } romState_t;

  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic shiftCmd;
    logic setRc;
    logic clrRc;
    logic setOd;
    logic clrOd;
    logic saveOd;
    logic restoreOd;
  } dpCtl_t;
endpackage

// File: rtl/romDatapath.sv
`timescale 1ns/1ps
module romDatapath
  import romLayerPkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             rxBit,
  input  logic [ID_W-1:0]  idValue,
  output logic             idBit,
  output logic [CMD_W-1:0] cmdNext,
  output logic             lastCmdBit,
  output logic             lastIdBit,
  output logic             rcFlag,
  output logic             odFlag
);
  localparam int CNT_W = $clog2(ID_W);

  logic [CNT_W-1:0] bitCount;
  logic [CMD_W-1:0] cmdShift;
  logic             odSaved;

  assign cmdNext    = {rxBit, cmdShift[CMD_W-1:1]};
  assign idBit      = idValue[bitCount];
  assign lastCmdBit = (bitCount == CNT_W'(CMD_W - 1));
  assign lastIdBit  = (bitCount == CNT_W'(ID_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCount <= '0;
      cmdShift <= '0;
      rcFlag   <= 1'b0;
      odFlag   <= 1'b0;
      odSaved  <= 1'b0;
    end else begin
      if (ctl.clrCount)      bitCount <= '0;
      else if (ctl.incCount) bitCount <= bitCount + 1'b1;

      if (ctl.shiftCmd) cmdShift <= cmdNext;

      if (ctl.clrRc)      rcFlag <= 1'b0;
      else if (ctl.setRc) rcFlag <= 1'b1;

      if (ctl.saveOd) odSaved <= odFlag;

      if (ctl.clrOd)          odFlag <= 1'b0;
      else if (ctl.setOd)     odFlag <= 1'b1;
      else if (ctl.restoreOd) odFlag <= odSaved;
    end
  end
endmodule

// File: rtl/romControl.sv
`timescale 1ns/1ps
module romControl
  import romLayerPkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             busResetLong,
  input  logic             slotValid,
  input  logic             rxBit,
  input  logic             idBit,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic             lastCmdBit,
  input  logic             lastIdBit,
  input  logic             rcFlag,
  output dpCtl_t           ctl,
  output logic             txEn,
  output logic             txBit,
  output logic             selected
);
  romState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (busReset) begin
      nextState    = ST_CMD;
      ctl.clrCount = 1'b1;
      ctl.clrOd    = busResetLong;
    end else if (slotValid) begin
      unique case (state)
        ST_CMD: begin
          ctl.shiftCmd = 1'b1;
          ctl.incCount = 1'b1;
          if (lastCmdBit) begin
            ctl.clrCount = 1'b1;
            case (cmdNext)
              OP_READ:   nextState = ST_READ;
              OP_MATCH: begin
                nextState  = ST_MATCH;
                ctl.clrRc  = 1'b1;
                ctl.saveOd = 1'b1;
              end
              OP_FAST_MTCH: begin
                nextState  = ST_MATCH;
                ctl.clrRc  = 1'b1;
                ctl.saveOd = 1'b1;
                ctl.setOd  = 1'b1;
              end
              OP_SEARCH: begin
                nextState = ST_SRCH_TRUE;
                ctl.clrRc = 1'b1;
              end
              OP_SKIP: begin
                nextState = ST_FUNC;
                ctl.clrRc = 1'b1;
              end
              OP_FAST_SKIP: begin
                nextState = ST_FUNC;
                ctl.clrRc = 1'b1;
                ctl.setOd = 1'b1;
              end
              OP_RESUME: nextState = rcFlag ? ST_FUNC : ST_IDLE;
              default:   nextState = ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          ctl.incCount = 1'b1;
          if (lastIdBit) nextState = ST_FUNC;
        end
        ST_MATCH: begin
          if (rxBit != idBit) begin
            nextState     = ST_IDLE;
            ctl.restoreOd = 1'b1;
          end else begin
            ctl.incCount = 1'b1;
            if (lastIdBit) begin
              nextState = ST_FUNC;
              ctl.setRc = 1'b1;
            end
          end
        end
        ST_SRCH_TRUE: nextState = ST_SRCH_COMP;
        ST_SRCH_COMP: nextState = ST_SRCH_PICK;
        ST_SRCH_PICK: begin
          if (rxBit != idBit) begin
            nextState = ST_IDLE;
          end else if (lastIdBit) begin
            nextState = ST_FUNC;
            ctl.setRc = 1'b1;
          end else begin
            ctl.incCount = 1'b1;
            nextState    = ST_SRCH_TRUE;
          end
        end
        default: nextState = state;
      endcase
    end
  end

  assign txEn     = (state == ST_READ) || (state == ST_SRCH_TRUE) || (state == ST_SRCH_COMP);
  assign txBit    = (state == ST_SRCH_COMP) ? ~idBit : idBit;
  assign selected = (state == ST_FUNC);
endmodule

// File: rtl/romCommandLayer.sv
`timescale 1ns/1ps
module romCommandLayer
  import romLayerPkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [ID_W-1:0] idValue,
  input  logic            busReset,
  input  logic            busResetLong,
  input  logic            slotValid,
  input  logic            rxBit,
  output logic            txEn,
  output logic            txBit,
  output logic            overdrive,
  output logic            resumeFlag,
  output logic            selected
);
  dpCtl_t           ctl;
  logic             idBit;
  logic [CMD_W-1:0] cmdNext;
  logic             lastCmdBit;
  logic             lastIdBit;

  romDatapath #(.ID_W(ID_W), .CMD_W(CMD_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxBit(rxBit), .idValue(idValue),
    .idBit(idBit), .cmdNext(cmdNext), .lastCmdBit(lastCmdBit),
    .lastIdBit(lastIdBit), .rcFlag(resumeFlag), .odFlag(overdrive)
  );

  romControl #(.CMD_W(CMD_W)) i_control (
    .clk(clk), .rstN(rstN), .busReset(busReset), .busResetLong(busResetLong),
    .slotValid(slotValid), .rxBit(rxBit), .idBit(idBit), .cmdNext(cmdNext),
    .lastCmdBit(lastCmdBit), .lastIdBit(lastIdBit), .rcFlag(resumeFlag),
    .ctl(ctl), .txEn(txEn), .txBit(txBit), .selected(selected)
  );
endmodule

// File: rtl/romLayerChecker.sv
`timescale 1ns/1ps
module romLayerChecker (
  input logic clk,
  input logic rstN,
  input logic busReset,
  input logic busResetLong,
  input logic slotValid,
  input logic txEn,
  input logic selected,
  input logic overdrive,
  input logic resumeFlag
);
  p_reset_deselect_r12: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!selected && !txEn));

  p_od_long_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && busResetLong) |=> !overdrive);

  p_od_short_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !busResetLong) |=> (overdrive == $past(overdrive)));

  p_rc_rise_select_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumeFlag) |-> selected);

  p_select_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !busReset) |=> selected);

  p_tx_not_selected_r3: assert property (@(posedge clk) disable iff (!rstN)
    txEn |-> !selected);

  p_quiet_no_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!slotValid && !busReset) |=> ($stable(selected) && $stable(txEn) && $stable(resumeFlag)));
endmodule

bind romCommandLayer romLayerChecker i_romLayerChecker (
  .clk(clk), .rstN(rstN), .busReset(busReset), .busResetLong(busResetLong),
  .slotValid(slotValid), .txEn(txEn), .selected(selected),
  .overdrive(overdrive), .resumeFlag(resumeFlag)
);

// File: tb/test_romCommandLayer.sv
`timescale 1ns/1ps
module test_romCommandLayer;
  logic        clk = 1'b0;
  logic        rstN, busReset, busResetLong, slotValid, rxBit;
  logic [63:0] idValue;
  logic        txEn, txBit, overdrive, resumeFlag, selected;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #2.5 clk = ~clk;

  romCommandLayer i_romCommandLayer (
    .clk(clk), .rstN(rstN), .idValue(idValue), .busReset(busReset),
    .busResetLong(busResetLong), .slotValid(slotValid), .rxBit(rxBit),
    .txEn(txEn), .txBit(txBit), .overdrive(overdrive),
    .resumeFlag(resumeFlag), .selected(selected)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic slot(input logic b);
    @(negedge clk); slotValid = 1'b1; rxBit = b;
    @(negedge clk); slotValid = 1'b0;
  endtask

  task automatic busRst(input logic lng);
    @(negedge clk); busReset = 1'b1; busResetLong = lng;
    @(negedge clk); busReset = 1'b0; busResetLong = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) slot(c[i]);
  endtask

  function automatic bit knownOp(input logic [7:0] c);
    return c == 8'h33 || c == 8'h55 || c == 8'hF0 || c == 8'hCC ||
           c == 8'hA5 || c == 8'h3C || c == 8'h69;
  endfunction

  // Sends address bits; flip >= 0 inverts that bit and stops there.
  task automatic sendAddr(input logic [63:0] id, input int flip);
    for (int i = 0; i < 64; i++) begin
      if (i == flip) begin slot(~id[i]); return; end
      slot(id[i]);
    end
  endtask

  task automatic readAll(output logic [63:0] got);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      got[i] = txEn & txBit;
      if (!txEn) got[i] = 1'bx;
      slot(1'b1);
    end
  endtask

  task automatic search(input logic [63:0] id, input int flip,
                        output logic [63:0] gotT, output logic [63:0] gotC);
    gotT = '0; gotC = '0;
    for (int i = 0; i < 64; i++) begin
      gotT[i] = txEn ? txBit : 1'bx; slot(1'b1);
      gotC[i] = txEn ? txBit : 1'bx; slot(1'b1);
      if (i == flip) begin slot(~id[i]); return; end
      slot(id[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] got, gotT, gotC;
    logic [7:0]  op;
    int          k, seedDummy;
    seedDummy = $urandom(32'd4242);
    rstN = 1'b0; busReset = 1'b0; busResetLong = 1'b0; slotValid = 1'b0; rxBit = 1'b0;
    idValue = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 selected", selected, 0);
    chk("R1 txEn", txEn, 0);
    chk("R1 overdrive", overdrive, 0);
    chk("R1 resumeFlag", resumeFlag, 0);
    sendCmd(8'hCC);
    chk("R1 ignored before bus reset", {txEn, selected}, 0);

    // R2 no action before 8th bit; R3 read
    busRst(1'b1);
    for (int i = 0; i < 7; i++) slot(OP33(i));
    chk("R2 seven bits no action", txEn, 0);
    slot(1'b0);
    chk("R2 read after 8th bit", txEn, 1);
    readAll(got);
    chk("R3 read bits", got, idValue);
    chk("R3 selected after read", selected, 1);
    chk("R6 read keeps rc clear", resumeFlag, 0);

    // R4 match success
    busRst(1'b1); sendCmd(8'h55); sendAddr(idValue, -1);
    chk("R4 match selected", selected, 1);
    chk("R4 match sets rc", resumeFlag, 1);
    busRst(1'b1); sendCmd(8'h33); readAll(got);
    chk("R6 read leaves rc set", resumeFlag, 1);
    busRst(1'b1); sendCmd(8'hA5);
    chk("R7 resume with rc", selected, 1);

    // R6 skip clears rc
    busRst(1'b1); sendCmd(8'hCC);
    chk("R6 skip selected", selected, 1);
    chk("R6 skip clears rc", resumeFlag, 0);

    // R4 mismatch, R7 resume without rc
    busRst(1'b1); sendCmd(8'h55); sendAddr(idValue, -1);
    busRst(1'b1); sendCmd(8'h55);
    chk("R6 match start clears rc", resumeFlag, 0);
    k = int'($urandom_range(63, 0));
    sendAddr(idValue, k);
    chk("R4 mismatch not selected", {selected, txEn, resumeFlag}, 0);
    repeat (5) slot(idValue[0]);
    chk("R4 idle until reset", {selected, txEn}, 0);
    busRst(1'b1); sendCmd(8'hA5);
    chk("R7 resume without rc idles", {selected, txEn}, 0);

    // R5 search
    busRst(1'b1); sendCmd(8'hF0);
    search(idValue, -1, gotT, gotC);
    chk("R5 search true bits", gotT, idValue);
    chk("R5 search complement bits", gotC, ~idValue);
    chk("R5 search selected", selected, 1);
    chk("R5 search sets rc", resumeFlag, 1);
    busRst(1'b1); sendCmd(8'hF0);
    k = int'($urandom_range(63, 0));
    search(idValue, k, gotT, gotC);
    chk("R5 search dropout silent", {txEn, selected}, 0);
    chk("R6 search start clears rc", resumeFlag, 0);
    slot(1'b1);
    chk("R5 dropout stays silent", txEn, 0);

    // R8, R10 overdrive skip and reset lengths
    busRst(1'b1); sendCmd(8'h55); sendAddr(idValue, -1);
    busRst(1'b1); sendCmd(8'h3C);
    chk("R8 odskip overdrive", overdrive, 1);
    chk("R8 odskip selected", selected, 1);
    chk("R6 odskip clears rc", resumeFlag, 0);
    busRst(1'b0);
    chk("R10 short reset keeps od", overdrive, 1);
    busRst(1'b1);
    chk("R10 long reset clears od", overdrive, 0);

    // R9 overdrive match
    busRst(1'b1); sendCmd(8'h69);
    chk("R9 od set after command", overdrive, 1);
    k = int'($urandom_range(63, 0));
    sendAddr(idValue, k);
    chk("R9 mismatch returns to standard", overdrive, 0);
    busRst(1'b1); sendCmd(8'h69); sendAddr(idValue, -1);
    chk("R9 match keeps od, selects, rc", {overdrive, selected, resumeFlag}, 3'b111);
    busRst(1'b1); sendCmd(8'h3C); busRst(1'b0); sendCmd(8'h69);
    sendAddr(idValue, 0);
    chk("R9 mismatch keeps prior od", overdrive, 1);
    busRst(1'b1);

    // R11 unknown code
    do op = 8'($urandom); while (knownOp(op));
    sendCmd(op);
    chk("R11 unknown idles", {selected, txEn}, 0);
    sendCmd(8'h33);
    chk("R11 no command until reset", {selected, txEn}, 0);
    busRst(1'b1); sendCmd(8'h33);
    chk("R11 recovers after reset", {txEn, txBit}, {1'b1, idValue[0]});

    // R12 abort mid-read, and reset wins over simultaneous slot
    for (int i = 0; i < 10; i++) slot(1'b1);
    busRst(1'b0);
    chk("R12 abort silent", {txEn, selected}, 0);
    sendCmd(8'h33);
    chk("R12 restart at bit 0", {txEn, txBit}, {1'b1, idValue[0]});
    @(negedge clk); busReset = 1'b1; slotValid = 1'b1; rxBit = 1'b1;
    @(negedge clk); busReset = 1'b0; slotValid = 1'b0;
    sendCmd(8'h33);
    readAll(got);
    chk("R12 reset wins over slot", got, idValue);

    // Random mix
    for (int n = 0; n < 12; n++) begin
      int sel;
      idValue = {$urandom, $urandom};
      sel = int'($urandom_range(3, 0));
      busRst(1'b1);
      case (sel)
        0: begin sendCmd(8'h33); readAll(got); chk("R3 random read", got, idValue); end
        1: begin sendCmd(8'h55); sendAddr(idValue, -1);
                 chk("R4 random match", {selected, resumeFlag}, 2'b11); end
        2: begin sendCmd(8'h55); sendAddr(idValue, int'($urandom_range(63, 0)));
                 chk("R4 random mismatch", {selected, resumeFlag}, 2'b00); end
        default: begin sendCmd(8'hF0); search(idValue, -1, gotT, gotC);
                 chk("R5 random search", {gotT, selected}, {idValue, 1'b1}); end
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end

  function automatic logic OP33(input int i);
    logic [7:0] c = 8'h33;
    return c[i];
  endfunction
endmodule